// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating

This block serialises characters for an asynchronous line. A character written into a single holding register moves into a frame shifter as soon as the transmitter is enabled and, when gating is selected, clear to send is low. The frame shifter then sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Between characters the line rests high.

The whole block runs on the falling edge of the transmit clock. Each bit lasts 1, 16, 32 or 64 of those edges. The character length, parity mode, stop count and rate are captured when a character moves into the shifter, so changing them later does not affect a character already in flight. The block flags when the holding register is free and when everything has left the line. It raises a transmit interrupt on each transfer. A command can cancel that interrupt and keep it quiet until the next write.

Top module: `tx_async_xmit`

## Requirements
- R1: After a synchronous active-low reset, txd is 1, buf_empty is 1, all_sent is 1 and tx_irq is 0.
- R2: A character moves from the holding register into the shifter only on an edge where tx_en is 1 and the register is full. While tx_en is 0, a written character waits, buf_empty stays 0 and txd stays 1.
- R3: With auto_en at 1, a transfer also needs cts_n at 0. The holding register may be written while cts_n is 1, and the line stays high until cts_n falls.
- R4: A frame is sent in this order: a start bit of 0, then char_len+1 data bits LSB first (char_len is 0 to 7, meaning 1 to 8 bits, and holding bits above the length are ignored), then a parity bit if par_en is 1, then the stop bits. The parity bit makes the number of ones in the data and parity together even when par_odd is 0, and odd when par_odd is 1. There is one stop bit of 1, or two when two_stop is 1.
- R5: Each bit lasts D falling edges, where rate_sel 0, 1, 2 and 3 give D = 1, 16, 32 and 64. txd changes only at a bit boundary. The format and rate are taken on the transfer edge.
- R6: On the transfer edge, buf_empty goes to 1, the start bit appears on txd, and tx_irq goes to 1 if the interrupt is armed.
- R7: Writing a character clears tx_irq and arms the interrupt. cmd_irq_clr clears tx_irq and disarms it, so the next transfer raises no interrupt until another write. A write wins over cmd_irq_clr on the same edge, and cmd_irq_clr wins over a transfer on the same edge.
- R8: all_sent is 0 while a frame is being sent or the holding register is full. It goes to 1 on the edge that ends the bit time of the last stop bit, provided the holding register is empty. It never affects tx_irq.
- R9: Writing while the holding register is full replaces the waiting character and leaves the frame in flight unchanged.
- R10: Clearing tx_en in the middle of a frame lets that frame finish. A character that is waiting stays in the holding register.
- R11: If a transfer is allowed on the edge that ends the last stop bit, the next start bit begins on that same edge, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to write |
| cmd_irq_clr | input | 1 | Command that clears and disarms the transmit interrupt |
| tx_en | input | 1 | Transmitter enable |
| auto_en | input | 1 | Requires cts_n low before a transfer |
| cts_n | input | 1 | Clear to send, active low, synchronous to clk |
| char_len | input | LEN_W | Data bits minus one |
| par_en | input | 1 | Adds a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| rate_sel | input | 2 | Divisor select: 1, 16, 32 or 64 |
| txd | output | 1 | Serial data, idles high |
| buf_empty | output | 1 | Holding register is free |
| all_sent | output | 1 | Line idle and holding register empty |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A bit counter or divider count that drifts shows at the ports as a txd edge in the wrong cycle. It therefore appears within one bit time, as little as a single edge at divisor 1. A stale flag in the holding register shows up at once, as a wrong buf_empty or all_sent on the next edge, or as a transfer that starts early or never starts. A wrong armed state shows only on the next transfer, as a tx_irq that rises or stays low when it should not. So the bench compares txd and every flag on every edge against a queue of expected line levels.

// File: rtl/tx_async_pkg.sv
// Package: shared types for the asynchronous transmitter.
// Assumes the rate select encoding is fixed at four divisors.
package tx_async_pkg;
    typedef enum logic [1:0] {
        RATE_X1  = 2'd0,
        RATE_X16 = 2'd1,
        RATE_X32 = 2'd2,
        RATE_X64 = 2'd3
    } rate_e;
endpackage

// File: rtl/tx_rate_div.sv
// Bit-time divider: counts falling clock edges while a frame is active and
// pulses bit_end on the last edge of each bit. The divisor is captured on
// restart, so a frame keeps its rate. Assumes CNT_W can hold 63.
module tx_rate_div
    import tx_async_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  logic  active,
    input  rate_e rate_in,
    output logic  bit_end
);
    rate_e            rate_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    // Last count value of a bit for the captured rate.
    always_comb begin
        case (rate_q)
            RATE_X1:  lim = '0;
            RATE_X16: lim = CNT_W'(15);
            RATE_X32: lim = CNT_W'(31);
            default:  lim = CNT_W'(63);
        endcase
    end

    // Bit boundary flag.
    assign bit_end = active && (cnt_q == lim);

    // Edge counter inside one bit time, and rate capture.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rate_q <= RATE_X1;
        end else if (restart) begin
            cnt_q  <= '0;
            rate_q <= rate_in;
        end else if (active) begin
            if (bit_end) cnt_q <= '0;
            else         cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    cnt_in_range_chk: assert property (@(negedge clk) disable iff (!rst_n)
        cnt_q <= lim);
endmodule

// File: rtl/tx_hold_buf.sv
// Holding register with full flag and transmit interrupt. A transfer empties
// the register and raises the interrupt if it is armed. The clear command
// drops and disarms it, and a write drops and re-arms it.
// Priority on one edge: write, then command, then transfer.
module tx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_irq_clr,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] hold_data,
    output logic              irq
);
    logic armed_q;

    // Register contents, full flag, interrupt and arm state.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            hold_data <= '0;
            irq       <= 1'b0;
            armed_q   <= 1'b0;
        end else begin
            if (take) begin
                full <= 1'b0;
                if (armed_q) irq <= 1'b1;
            end
            if (cmd_irq_clr) begin
                irq     <= 1'b0;
                armed_q <= 1'b0;
            end
            if (wr_en) begin
                hold_data <= wr_data;
                full      <= 1'b1;
                irq       <= 1'b0;
                armed_q   <= 1'b1;
            end
        end
    end

    // R7
    irq_only_when_empty_chk: assert property (@(negedge clk) disable iff (!rst_n)
        irq |-> !full);
    // R6
    irq_rise_needs_take_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(take));
endmodule

// File: rtl/tx_frame_shift.sv
// Frame builder and shifter. On load it builds the start, data, parity and
// stop bits from the current format inputs, then shifts one bit per bit_end.
// The line is high when no frame is active.
// Assumes bit_end is low whenever busy is low.
module tx_frame_shift #(
    parameter int DATA_W  = 8,
    parameter int LEN_W   = 3,
    parameter int FRAME_W = 12,
    parameter int BITS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              bit_end,
    output logic              busy,
    output logic              frame_done,
    output logic              txd
);
    logic [DATA_W-1:0]  data_mask;
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] sr_q;
    logic [BITS_W-1:0]  nbits;
    logic [BITS_W-1:0]  left_q;
    logic               par_bit;

    // Mask of the data bits that belong to the programmed length.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) data_mask[i] = (i <= int'(len_code));
    end

    // Even parity over the used bits, inverted for odd parity.
    assign par_bit = (^(load_data & data_mask)) ^ par_odd;

    // Frame image: bit 0 goes out first, unused positions are mark.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data_mask[i]) frame[i + 1] = load_data[i];
        end
        if (par_en) frame[int'(len_code) + 2] = par_bit;
    end

    // Total bits in the frame: start, data, parity, stops.
    assign nbits = BITS_W'(2) + BITS_W'(len_code) + BITS_W'(par_en)
                 + (two_stop ? BITS_W'(2) : BITS_W'(1));

    // End of the last stop bit.
    assign frame_done = busy && bit_end && (left_q == BITS_W'(1));

    // Shift register, bits left and activity flag.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            sr_q   <= '1;
            left_q <= '0;
            busy   <= 1'b0;
        end else if (load) begin
            sr_q   <= frame;
            left_q <= nbits;
            busy   <= 1'b1;
        end else if (busy && bit_end) begin
            sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
            if (left_q == BITS_W'(1)) busy <= 1'b0;
        end
    end

    // Line level: current frame bit, mark when idle.
    assign txd = busy ? sr_q[0] : 1'b1;

    // R4
    start_bit_low_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
    // R8
    bits_left_live_chk: assert property (@(negedge clk) disable iff (!rst_n)
        busy |-> (left_q != '0));
endmodule

// File: rtl/tx_async_xmit.sv
// Top of the asynchronous transmitter. It decides when the holding register
// moves into the shifter and drives the status outputs.
// Assumes cts_n and all control inputs are synchronous to the falling edge of
// clk, and that MAX_DIV is at least 64.
module tx_async_xmit
    import tx_async_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MAX_DIV = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       cmd_irq_clr,
    input  logic                       tx_en,
    input  logic                       auto_en,
    input  logic                       cts_n,
    input  logic [$clog2(DATA_W)-1:0]  char_len,
    input  logic                       par_en,
    input  logic                       par_odd,
    input  logic                       two_stop,
    input  logic [1:0]                 rate_sel,
    output logic                       txd,
    output logic                       buf_empty,
    output logic                       all_sent,
    output logic                       tx_irq
);
    localparam int LEN_W   = $clog2(DATA_W);
    localparam int CNT_W   = $clog2(MAX_DIV);
    localparam int FRAME_W = DATA_W + 4;
    localparam int BITS_W  = $clog2(FRAME_W + 1);

    logic              buf_full;
    logic [DATA_W-1:0] hold_data;
    logic              busy;
    logic              frame_done;
    logic              bit_end;
    logic              load;

    // Transfer when a character waits, the line is allowed, and the shifter is free.
    assign load = buf_full && tx_en && (!auto_en || !cts_n) && (!busy || frame_done);

    tx_hold_buf #(.DATA_W(DATA_W)) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cmd_irq_clr(cmd_irq_clr),
        .take       (load),
        .full       (buf_full),
        .hold_data  (hold_data),
        .irq        (tx_irq)
    );

    tx_rate_div #(.CNT_W(CNT_W)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(load),
        .active (busy),
        .rate_in(rate_e'(rate_sel)),
        .bit_end(bit_end)
    );

    tx_frame_shift #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .FRAME_W(FRAME_W),
        .BITS_W (BITS_W)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (hold_data),
        .len_code  (char_len),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .two_stop  (two_stop),
        .bit_end   (bit_end),
        .busy      (busy),
        .frame_done(frame_done),
        .txd       (txd)
    );

    // Status outputs.
    assign buf_empty = !buf_full;
    assign all_sent  = !busy && !buf_full;

    // R2
    start_needs_enable_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_en));
    // R3
    start_needs_cts_chk: assert property (@(negedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(auto_en)) |-> !$past(cts_n));
    // R5
    line_steady_in_bit_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (busy && !bit_end) |=> $stable(txd));
    // R8
    all_sent_mark_chk: assert property (@(negedge clk) disable iff (!rst_n)
        all_sent |-> txd);
endmodule

// File: tb/tx_async_xmit_tb.sv
`timescale 1ns/1ps
// Bench: a queue of expected line levels, one entry per falling edge, plus
// behavioural buffer and interrupt state, compared with the ports on every
// rising edge.
module tx_async_xmit_tb_top;
    logic       clk = 1'b1;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_irq_clr = 1'b0;
    logic       tx_en = 1'b0;
    logic       auto_en = 1'b0;
    logic       cts_n = 1'b1;
    logic [2:0] char_len = 3'd7;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       txd, buf_empty, all_sent, tx_irq;

    always #2.5 clk = ~clk;

    tx_async_xmit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_irq_clr(cmd_irq_clr), .tx_en(tx_en), .auto_en(auto_en),
        .cts_n(cts_n), .char_len(char_len), .par_en(par_en),
        .par_odd(par_odd), .two_stop(two_stop), .rate_sel(rate_sel),
        .txd(txd), .buf_empty(buf_empty), .all_sent(all_sent), .tx_irq(tx_irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    started = 0;
    string cur_req = "R1";

    bit       mq[$];
    bit       m_full = 0, m_irq = 0, m_armed = 0;
    bit [7:0] m_buf = '0;

    task automatic chk(input bit got, input bit exp, input string req, input string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // Expected levels of one frame, one queue entry per edge.
    task automatic push_frame(input bit [7:0] d);
        int bits[$];
        int dv;
        int ones = 0;
        dv = (rate_sel == 2'd0) ? 1 : (1 << (int'(rate_sel) + 3));
        bits.push_back(0);
        for (int i = 0; i <= int'(char_len); i++) begin
            bits.push_back(int'(d[i]));
            ones += int'(d[i]);
        end
        if (par_en) bits.push_back(((ones % 2) == 1) ^ par_odd ? 1 : 0);
        bits.push_back(1);
        if (two_stop) bits.push_back(1);
        foreach (bits[k]) for (int r = 0; r < dv; r++) mq.push_back(bits[k][0]);
    endtask

    // Behavioural model, updated on the active edge from the inputs.
    always @(negedge clk) begin
        started <= 1;
        if (!rst_n) begin
            mq.delete();
            m_full = 0; m_irq = 0; m_armed = 0;
        end else begin
            if (mq.size() > 0) void'(mq.pop_front());
            if (mq.size() == 0 && m_full && tx_en && (!auto_en || !cts_n)) begin
                push_frame(m_buf);
                m_full = 0;
                if (m_armed) m_irq = 1;
            end
            if (cmd_irq_clr) begin m_irq = 0; m_armed = 0; end
            if (wr_en) begin m_buf = wr_data; m_full = 1; m_irq = 0; m_armed = 1; end
        end
    end

    // Compare every cycle, and watchdog.
    always @(posedge clk) begin
        cycles++;
        if (started) begin
            chk(txd, (mq.size() > 0) ? mq[0] : 1'b1, cur_req, "txd");
            chk(buf_empty, !m_full, cur_req, "buf_empty");
            chk(all_sent, (mq.size() == 0) && !m_full, cur_req, "all_sent");
            chk(tx_irq, m_irq, cur_req, "tx_irq");
        end
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input bit [7:0] d);
        @(posedge clk); wr_en <= 1'b1; wr_data <= d;
        @(posedge clk); wr_en <= 1'b0;
    endtask

    task automatic cmd();
        @(posedge clk); cmd_irq_clr <= 1'b1;
        @(posedge clk); cmd_irq_clr <= 1'b0;
    endtask

    task automatic fmt(input bit [2:0] l, input bit pe, input bit po, input bit ts, input bit [1:0] r);
        @(posedge clk);
        char_len <= l; par_en <= pe; par_odd <= po; two_stop <= ts; rate_sel <= r;
    endtask

    task automatic drain();
        do @(posedge clk); while (mq.size() > 0 || m_full);
        cyc(3);
    endtask

    initial begin
        cyc(4);
        rst_n <= 1'b1;
        cyc(2);
        // R1 reset state
        chk(txd, 1'b1, "R1", "txd after reset");
        chk(buf_empty, 1'b1, "R1", "buf_empty after reset");
        chk(all_sent, 1'b1, "R1", "all_sent after reset");
        chk(tx_irq, 1'b0, "R1", "tx_irq after reset");

        // R2: held while disabled
        cur_req = "R2";
        fmt(3'd7, 0, 0, 0, 2'd0);
        wr(8'hA5);
        cyc(20);
        chk(buf_empty, 1'b0, "R2", "waits while disabled");
        chk(txd, 1'b1, "R2", "line idle while disabled");
        tx_en <= 1'b1;
        drain();

        // R4: formats
        cur_req = "R4";
        fmt(3'd4, 1, 0, 0, 2'd0); wr(8'hF6); drain();
        fmt(3'd6, 1, 1, 1, 2'd0); wr(8'hD3); drain();
        fmt(3'd0, 0, 0, 1, 2'd0); wr(8'hFE); drain();
        fmt(3'd5, 1, 1, 0, 2'd1); wr(8'h2B); drain();

        // R5: rates
        cur_req = "R5";
        fmt(3'd7, 1, 0, 1, 2'd2); wr(8'h96); drain();
        fmt(3'd7, 0, 0, 0, 2'd3); wr(8'h4C); drain();

        // R3: clear-to-send gating
        cur_req = "R3";
        fmt(3'd7, 0, 0, 0, 2'd0);
        auto_en <= 1'b1; cts_n <= 1'b1;
        wr(8'h81);
        cyc(30);
        chk(txd, 1'b1, "R3", "line held while cts high");
        chk(buf_empty, 1'b0, "R3", "buffer loaded early");
        cts_n <= 1'b0;
        drain();
        auto_en <= 1'b0; cts_n <= 1'b1;

        // R7: interrupt clear and disarm
        cur_req = "R7";
        tx_en <= 1'b0;
        wr(8'h5A); cmd();
        tx_en <= 1'b1;
        drain();
        chk(tx_irq, 1'b0, "R7", "no irq after disarm");
        wr(8'h3C); cyc(3);
        chk(tx_irq, 1'b1, "R6", "irq on transfer");
        chk(buf_empty, 1'b1, "R6", "empty on transfer");
        cmd(); cyc(2);
        chk(tx_irq, 1'b0, "R7", "irq cleared by command");
        drain();
        cur_req = "R6";
        wr(8'h66); cyc(2); wr(8'h99); drain();

        // R9: overwrite while full
        cur_req = "R9";
        fmt(3'd7, 0, 0, 0, 2'd1);
        wr(8'h11); cyc(5); wr(8'h22); cyc(3); wr(8'h33);
        drain();

        // R10: disable mid-frame
        cur_req = "R10";
        wr(8'h0F); cyc(40);
        tx_en <= 1'b0;
        wr(8'hF0);
        do @(posedge clk); while (mq.size() > 0);
        cyc(10);
        chk(buf_empty, 1'b0, "R10", "waiting char kept");
        chk(all_sent, 1'b0, "R10", "all_sent low with char waiting");
        chk(txd, 1'b1, "R10", "line idle after frame");
        tx_en <= 1'b1;
        drain();

        // R11 and R8: back to back at divisor 1
        cur_req = "R11";
        fmt(3'd7, 1, 1, 0, 2'd0);
        wr(8'hC3); wr(8'h3C); cyc(4); wr(8'h5F);
        drain();
        cur_req = "R8";
        fmt(3'd2, 0, 0, 1, 2'd1); wr(8'h05); drain();
        chk(all_sent, 1'b1, "R8", "all_sent after last stop");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule